// File: doc/BRIEF.md
# Two-Stage Reload Watchdog Timer

A system watchdog with a small register bus. A down-counter steps once per pulse on a coarse `tick` input. Software programs an initial tick count, clears a halt bit to start counting, and then services the timer regularly by writing the reload register. With a 0.6 s tick, a timeout of S seconds needs an initial count of S*10/6.

If the counter is not serviced, the timer expires when a tick finds it at zero. The first expiry raises a sticky timeout status, reloads the counter and arms the block. A second expiry, while still armed and with no service in between, issues a one-cycle system reset request and puts the timer back into the halted state. A sticky no-reboot flag can block that request; the block then records that a reset was withheld.

Initial values below 4 are refused. Out of reset the timer is halted and reboots are blocked, so it does nothing until software enables it. A parameter selects a 6-bit counter with byte-wide field access or a 10-bit counter with halfword access.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the halt bit and the no-reboot flag are 1. The initial value and the counter both equal the `INIT_DEF` parameter. Both status registers read 0, and `timeout_sts` and `sys_rst_req` are low.
- R2: Control register 0x08, bit 11, is the halt bit and reads back as written. While it is 0, each `tick` pulse lowers the counter by one. While it is 1, the counter does not move. The counter reads at 0x00 in the low CNT_W bits.
- R3: Any write to offset 0x00, with any byte enable, loads the counter with the current initial value and disarms the second stage.
- R4: The initial value sits in the low CNT_W bits of offset 0x02. A write takes effect only if it carries the byte enables that cover the field (the low byte in the 6-bit variant) and the value is at least 4. Values 0 to 3 leave the old value in force. Writing 0x02 never changes the counter.
- R5: When a tick finds the counter at 0 and the block is not armed, status register 0x04 bit 3 and `timeout_sts` go to 1. The counter reloads and the block becomes armed. Writing 1 to bit 3 clears it.
- R6: When a tick finds the counter at 0 while armed and the no-reboot flag is 0, `sys_rst_req` is high for exactly one cycle. The halt bit returns to 1, the counter reloads, and status register 0x06 bit 0 is set.
- R7: The no-reboot flag at offset 0x0A bit 0 reads back as written. While it is 1, a second expiry produces no reset request. Instead it sets status 0x06 bit 1, reloads the counter, keeps counting, and leaves the block armed.
- R8: Bits 1:0 of status register 0x06 are cleared by writing 1 to them; writing 3 clears both.
- R9: Setting the halt bit disarms the second stage, so the next expiry after a restart is a first expiry.
- R10: With `WIDE_CNT`=1, the counter and the initial value are 10 bits wide. An initial-value write then needs both byte enables; a low-byte-only write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle coarse time-base pulse |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 2 | Byte enables for the halfword write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| timeout_sts | output | 1 | Level of the sticky first-expiry status |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds two copies that share the bus and the tick. The first uses the 6-bit variant with `INIT_DEF`=5, so first expiry, second expiry, a withheld reset and the halt-disarm case are each reached within a few ticks. The second uses the 10-bit variant with its default value of 50. It accepts initial counts above 63 and exercises the rule that both byte enables are needed, and its counter is read back across the full 10-bit range.

// File: rtl/tick_watchdog_pkg.sv
package tick_watchdog_pkg;
  localparam int MIN_INIT = 4;
  localparam int HALT_BIT = 11;
  localparam int TMO_BIT  = 3;
  // halfword index = byte offset [4:1]
  localparam logic [3:0] IX_COUNT = 4'h0;
  localparam logic [3:0] IX_INIT  = 4'h1;
  localparam logic [3:0] IX_STS1  = 4'h2;
  localparam logic [3:0] IX_STS2  = 4'h3;
  localparam logic [3:0] IX_CTRL  = 4'h4;
  localparam logic [3:0] IX_NORB  = 4'h5;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W    = 6,
  parameter int INIT_DEF = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             noreboot_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             first_exp_o,
  output logic             second_exp_o,
  output logic             rst_fire_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             rst_req_q;
  logic             adv, at_zero;

  always_comb begin
    adv          = tick_i && !halt_i;
    at_zero      = (cnt_q == '0);
    first_exp_o  = adv && at_zero && !armed_q && !reload_i;
    second_exp_o = adv && at_zero &&  armed_q && !reload_i;
    rst_fire_o   = second_exp_o && !noreboot_i;

    cnt_d = cnt_q;
    if (reload_i)     cnt_d = init_i;
    else if (adv)     cnt_d = at_zero ? init_i : cnt_q - CNT_W'(1);

    armed_d = armed_q;
    if (reload_i || halt_i || rst_fire_o) armed_d = 1'b0;
    else if (first_exp_o)                 armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= CNT_W'(INIT_DEF);
      armed_q   <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      armed_q   <= armed_d;
      rst_req_q <= rst_fire_o;
    end
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = rst_req_q;

  // R2: halted counter holds
  p_halt_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !reload_i) |=> $stable(cnt_q));
  // R2: one step per tick
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !halt_i && !reload_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R3: reload restores initial value
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == $past(init_i)));
  // R6: reset only when armed, one cycle wide
  p_rst_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> $past(armed_q));
  p_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);
  // R7: no-reboot flag withholds reset
  p_noreboot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> !$past(noreboot_i));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import tick_watchdog_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter bit WIDE     = 1'b0,
  parameter int INIT_DEF = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [1:0]       bus_be,
  input  logic [15:0]      bus_wdata,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             first_exp_i,
  input  logic             second_exp_i,
  input  logic             rst_fire_i,
  output logic [CNT_W-1:0] init_o,
  output logic             halt_o,
  output logic             noreboot_o,
  output logic             reload_o,
  output logic             tmo_o,
  output logic [15:0]      rdata_o
);
  logic [CNT_W-1:0] init_q, init_d;
  logic             halt_q, halt_d, norb_q, norb_d, tmo_q, tmo_d;
  logic [1:0]       sts2_q, sts2_d, clr2;
  logic             init_en, halt_en, norb_en;
  logic             aligned, field_ok;
  logic             wr_cnt, wr_init, wr_sts1, wr_sts2, wr_ctrl, wr_norb;
  logic             unused_bits;

  assign unused_bits = ^bus_wdata;

  always_comb begin
    aligned  = !bus_addr[0];
    field_ok = WIDE ? (bus_be == 2'b11) : bus_be[0];
    wr_cnt   = bus_wr && aligned && (bus_addr[4:1] == IX_COUNT);
    wr_init  = bus_wr && aligned && (bus_addr[4:1] == IX_INIT);
    wr_sts1  = bus_wr && aligned && (bus_addr[4:1] == IX_STS1) && bus_be[0];
    wr_sts2  = bus_wr && aligned && (bus_addr[4:1] == IX_STS2) && bus_be[0];
    wr_ctrl  = bus_wr && aligned && (bus_addr[4:1] == IX_CTRL) && bus_be[1];
    wr_norb  = bus_wr && aligned && (bus_addr[4:1] == IX_NORB) && bus_be[0];

    reload_o = wr_cnt && (bus_be != 2'b00);

    init_en  = wr_init && field_ok && (bus_wdata[CNT_W-1:0] >= CNT_W'(MIN_INIT));
    init_d   = bus_wdata[CNT_W-1:0];

    halt_en  = rst_fire_i || wr_ctrl;
    halt_d   = rst_fire_i ? 1'b1 : bus_wdata[HALT_BIT];

    norb_en  = wr_norb;
    norb_d   = bus_wdata[0];

    tmo_d    = first_exp_i || (tmo_q && !(wr_sts1 && bus_wdata[TMO_BIT]));

    clr2     = wr_sts2 ? bus_wdata[1:0] : 2'b00;
    sts2_d   = {second_exp_i && !rst_fire_i, rst_fire_i} | (sts2_q & ~clr2);

    rdata_o = 16'h0000;
    if (aligned) begin
      case (bus_addr[4:1])
        IX_COUNT: rdata_o = 16'(cnt_i);
        IX_INIT:  rdata_o = 16'(init_q);
        IX_STS1:  rdata_o = 16'(tmo_q) << TMO_BIT;
        IX_STS2:  rdata_o = 16'(sts2_q);
        IX_CTRL:  rdata_o = 16'(halt_q) << HALT_BIT;
        IX_NORB:  rdata_o = 16'(norb_q);
        default:  rdata_o = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= CNT_W'(INIT_DEF);
      halt_q <= 1'b1;
      norb_q <= 1'b1;
      tmo_q  <= 1'b0;
      sts2_q <= 2'b00;
    end else begin
      if (init_en) init_q <= init_d;
      if (halt_en) halt_q <= halt_d;
      if (norb_en) norb_q <= norb_d;
      tmo_q  <= tmo_d;
      sts2_q <= sts2_d;
    end
  end

  assign init_o     = init_q;
  assign halt_o     = halt_q;
  assign noreboot_o = norb_q;
  assign tmo_o      = tmo_q;

  // R4: initial value never below the floor
  p_init_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    init_q >= CNT_W'(MIN_INIT));
  // R5: first expiry raises timeout status
  p_first_sets_tmo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    first_exp_i |=> tmo_q);
  // R6: reset event returns timer to halt
  p_halt_after_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fire_i |=> halt_q);
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter bit WIDE_CNT = 1'b0,
  parameter int INIT_DEF = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        timeout_sts,
  output logic        sys_rst_req
);
  localparam int CNT_W = WIDE_CNT ? 10 : 6;

  logic             rst_n_s;
  logic [CNT_W-1:0] init_w, cnt_w;
  logic             halt_w, norb_w, reload_w;
  logic             first_w, second_w, fire_w;

  wdt_rst_sync u_sync (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  wdt_regs #(.CNT_W(CNT_W), .WIDE(WIDE_CNT), .INIT_DEF(INIT_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .cnt_i(cnt_w), .first_exp_i(first_w), .second_exp_i(second_w), .rst_fire_i(fire_w),
    .init_o(init_w), .halt_o(halt_w), .noreboot_o(norb_w), .reload_o(reload_w),
    .tmo_o(timeout_sts), .rdata_o(bus_rdata)
  );

  wdt_core #(.CNT_W(CNT_W), .INIT_DEF(INIT_DEF)) u_core (
    .clk(clk), .rst_n(rst_n_s),
    .tick_i(tick), .halt_i(halt_w), .noreboot_i(norb_w), .reload_i(reload_w),
    .init_i(init_w), .cnt_o(cnt_w),
    .first_exp_o(first_w), .second_exp_o(second_w), .rst_fire_o(fire_w),
    .rst_req_o(sys_rst_req)
  );
endmodule

// File: tb/sim_tick_watchdog.sv
module sim_tick_watchdog;
  logic        clk = 1'b0;
  logic        rst_n, tick, bus_wr;
  logic [4:0]  bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] rdata0, rdata1;
  logic        tmo0, tmo1, rreq0, rreq1;
  int total = 0, bad = 0, rst_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_watchdog #(.WIDE_CNT(1'b0), .INIT_DEF(5)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
    .timeout_sts(tmo0), .sys_rst_req(rreq0));

  tick_watchdog #(.WIDE_CNT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
    .timeout_sts(tmo1), .sys_rst_req(rreq1));

  always @(negedge clk) if (rreq0) rst_seen++;

  localparam logic [1:0] OP_W = 2'd0, OP_T = 2'd1, OP_RC = 2'd2, OP_RS = 2'd3;
  function automatic logic [26:0] e(logic [1:0] op, logic [3:0] rq, logic [4:0] a, logic [15:0] d);
    return {op, rq, a, d};
  endfunction

  localparam int NV = 56;
  localparam logic [26:0] TBL [NV] = '{
    e(OP_RC,1,5'h00,16'h0005), e(OP_RC,1,5'h08,16'h0800), e(OP_RC,1,5'h0A,16'h0001), // R1
    e(OP_RC,1,5'h04,16'h0000),
    e(OP_T ,2,5'h00,16'd1),    e(OP_RC,2,5'h00,16'h0005),                          // R2 halted
    e(OP_W ,4,5'h02,16'h0002), e(OP_RC,4,5'h02,16'h0005),                          // R4 floor
    e(OP_W ,4,5'h02,16'h0003), e(OP_RC,4,5'h02,16'h0005),
    e(OP_W ,4,5'h02,16'h0004), e(OP_RC,4,5'h02,16'h0004), e(OP_RC,4,5'h00,16'h0005),
    e(OP_W ,3,5'h00,16'h0000), e(OP_RC,3,5'h00,16'h0004),                          // R3
    e(OP_W ,7,5'h0A,16'h0000), e(OP_RC,7,5'h0A,16'h0000),                          // R7 readback
    e(OP_W ,2,5'h08,16'h0000), e(OP_RC,2,5'h08,16'h0000),
    e(OP_T ,2,5'h00,16'd1),    e(OP_RC,2,5'h00,16'h0003),
    e(OP_T ,2,5'h00,16'd3),    e(OP_RC,2,5'h00,16'h0000),
    e(OP_T ,5,5'h00,16'd1),    e(OP_RC,5,5'h04,16'h0008), e(OP_RC,5,5'h00,16'h0004), // R5
    e(OP_RS,5,5'h00,16'd0),
    e(OP_W ,3,5'h00,16'h0000), e(OP_T ,3,5'h00,16'd5), e(OP_RS,3,5'h00,16'd0),       // R3 disarm
    e(OP_W ,5,5'h04,16'h0008), e(OP_RC,5,5'h04,16'h0000),
    e(OP_T ,6,5'h00,16'd5),    e(OP_RS,6,5'h00,16'd1),                              // R6
    e(OP_RC,6,5'h08,16'h0800), e(OP_RC,6,5'h06,16'h0001), e(OP_RC,6,5'h00,16'h0004),
    e(OP_W ,8,5'h06,16'h0003), e(OP_RC,8,5'h06,16'h0000),                          // R8
    e(OP_W ,7,5'h0A,16'h0001), e(OP_RC,7,5'h0A,16'h0001), e(OP_W ,7,5'h08,16'h0000),
    e(OP_T ,7,5'h00,16'd10),   e(OP_RS,7,5'h00,16'd1),
    e(OP_RC,7,5'h06,16'h0002), e(OP_RC,7,5'h08,16'h0000),
    e(OP_W ,9,5'h08,16'h0800), e(OP_RC,9,5'h08,16'h0800),                          // R9
    e(OP_T ,9,5'h00,16'd1),    e(OP_RC,9,5'h00,16'h0004),
    e(OP_W ,9,5'h0A,16'h0000), e(OP_W ,9,5'h08,16'h0000), e(OP_W ,9,5'h04,16'h0008),
    e(OP_T ,9,5'h00,16'd5),    e(OP_RS,9,5'h00,16'd1),  e(OP_RC,9,5'h04,16'h0008)
  };

  task automatic do_write(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic check(input int rq, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic read_chk(input bit wide, input int rq, input logic [4:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(rq, $sformatf("u%0d read 0x%02h", wide, a), wide ? rdata1 : rdata0, exp);
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_be = 2'b00;
    bus_addr = 5'h00; bus_wdata = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [4:0]  a;
      logic [15:0] d;
      {op, rq, a, d} = TBL[i];
      case (op)
        OP_W:  do_write(a, d, 2'b11);
        OP_T:  do_ticks(int'(d));
        OP_RC: read_chk(1'b0, int'(rq), a, d);
        default: begin
          @(negedge clk);
          check(int'(rq), "reset pulse count", 16'(rst_seen), d);
        end
      endcase
    end

    // R1: reset in the middle of a run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_chk(1'b0, 1, 5'h08, 16'h0800);
    read_chk(1'b0, 1, 5'h0A, 16'h0001);
    read_chk(1'b0, 1, 5'h00, 16'h0005);
    read_chk(1'b0, 1, 5'h06, 16'h0000);
    check(1, "timeout_sts after reset", 16'(tmo0), 16'h0000);
    read_chk(1'b1, 1, 5'h02, 16'd50);

    // R10: wide init needs both byte enables; R4: narrow takes low byte, field masked
    do_write(5'h02, 16'h0123, 2'b11);
    read_chk(1'b1, 10, 5'h02, 16'h0123);
    read_chk(1'b0, 4, 5'h02, 16'h0023);
    do_write(5'h02, 16'h0007, 2'b01);
    read_chk(1'b1, 10, 5'h02, 16'h0123);
    read_chk(1'b0, 4, 5'h02, 16'h0007);

    // R5: timeout_sts port; R10: wide counter readback
    do_write(5'h00, 16'h0000, 2'b11);
    do_write(5'h08, 16'h0000, 2'b10);
    do_ticks(8);
    @(negedge clk);
    check(5, "u0 timeout_sts after first expiry", 16'(tmo0), 16'h0001);
    check(10, "u1 timeout_sts still low", 16'(tmo1), 16'h0000);
    read_chk(1'b1, 10, 5'h00, 16'h011B);
    read_chk(1'b0, 5, 5'h00, 16'h0007);

    done = 1;
    report();
    $finish;
  end
endmodule